// File: doc/BRIEF.md
# Multi-Wide In-Order Retire Controller

This block sits at the head of a reorder buffer and decides, each cycle, which of the oldest instructions leave it. A thread selector offers an ordered list of candidate slots. Each slot carries a grant, the owning thread and the attributes of that thread's current head entry: ready, squashed, executed, non-speculative (which covers serializing operations, store-conditionals and barriers), load, fault and a "not counted" flag for nops and instruction prefetches. The controller walks the slots oldest first and pops entries until a rule stops it or the configured retire width is used up.

Some heads cannot simply retire. An unexecuted head sends its sequence number back as a non-speculative release, which also clears its can-commit mark. An unexecuted load adds an uncached replay request to that release. A faulting head starts a trap and arms a per-thread timer that later pulses a trap squash. A thread with a trap in flight is skipped. Successful retirements advance that thread's architectural PC and next PC. A counter records the cycles that reached the width limit.

Top module: `retire_ctrl`

## Requirements
- R1: Slots are evaluated in index order. The walk stops at the first slot that has no grant or whose head is not ready, and no later slot is popped in that cycle.
- R2: A squashed head is popped without adding to `retired_count` and without changing its thread's PC. Squashed pops do not use retire width, so up to NSLOT entries can leave in one cycle.
- R3: An unexecuted non-speculative head stops the walk. If it is the first candidate to retire in the cycle (`retired_count` still 0) and `stores_pending` is low, it raises `release_valid` with its sequence number and thread; otherwise it only waits.
- R4: An unexecuted load head stops the walk and always raises `release_valid` together with `replay_req`, whatever its position and whatever `stores_pending` is.
- R5: A faulting executed head stops the walk. It raises `trap_start` with its thread only if no instruction retired before it in the cycle and `stores_pending` is low. After that clock edge `trap_pending` for the thread is 1. `trap_squash` for the thread rises TRAP_LAT-1 edges later and lasts one cycle; the following edge clears `trap_pending`.
- R6: Each ordinary retirement pops its slot and increments `retired_count`. `done_seq` shows the sequence number of the last slot retired in the cycle. On the next edge the thread's PC becomes that slot's next-PC input and its next PC becomes that value plus 4.
- R7: A head flagged "not counted" retires like any other (pop, `retired_count`, PC) but does not add to `completed_count`.
- R8: At most W entries retire per cycle. `width_hit` is 1 exactly when `retired_count` equals W, and each such cycle increments `width_hit_cnt` by one on the edge.
- R9: `free_update` is 1 in every cycle in which at least one slot is popped, and 0 otherwise.
- R10: While `trap_pending` is 1 for a thread, a slot granted to that thread is treated as having no grant.
- R11: After reset every PC equals RESET_PC, every next PC equals RESET_PC+4, and `width_hit_cnt` and all `trap_pending` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_grant | input | NSLOT (6) | Slot carries a selected head |
| slot_tid | input | NSLOT*TIDW (6) | Thread of each slot |
| slot_ready | input | NSLOT | Head ready to be considered |
| slot_squashed | input | NSLOT | Head was squashed |
| slot_executed | input | NSLOT | Head has executed |
| slot_nonspec | input | NSLOT | Head must run non-speculatively |
| slot_load | input | NSLOT | Head is a load |
| slot_fault | input | NSLOT | Head carries a fault |
| slot_nocount | input | NSLOT | Head is a nop or instruction prefetch |
| slot_seq | input | NSLOT*SEQW (96) | Sequence number per slot |
| slot_npc | input | NSLOT*PCW (192) | Next PC of each head |
| stores_pending | input | 1 | Stores still awaiting writeback |
| head_pop | output | NSLOT | Remove this slot's head from the buffer |
| retired_count | output | CNTW (3) | Instructions retired this cycle |
| completed_count | output | CNTW (3) | Retired instructions that are counted |
| width_hit | output | 1 | Retire width reached this cycle |
| width_hit_cnt | output | HITW (16) | Cycles that reached the width |
| free_update | output | 1 | Free-entry count must be re-sent |
| done_valid | output | 1 | At least one retirement this cycle |
| done_seq | output | SEQW (16) | Sequence number of last retired head |
| release_valid | output | 1 | Non-speculative release (clears can-commit) |
| release_tid | output | TIDW (1) | Thread of the release |
| release_seq | output | SEQW | Sequence number released |
| replay_req | output | 1 | Uncached load replay with the release |
| trap_start | output | 1 | Start trap handling |
| trap_tid | output | TIDW | Thread of the trap |
| trap_pending | output | NT (2) | Per-thread trap in flight |
| trap_squash | output | NT | Per-thread trap-squash pulse |
| arch_pc | output | NT*PCW (64) | Architectural PC per thread |
| arch_npc | output | NT*PCW | Architectural next PC per thread |

## Verification
Pop, count, release, replay, trap-start, done and free-update results are combinational, so they are due in the same cycle as the slot inputs. The bench drives the slots just after a falling edge and compares these results one nanosecond later, before the next rising edge. The PC, next PC, width-hit counter and trap-pending state change on the rising edge, so they are compared one nanosecond after that edge. The trap squash pulse is counted edge by edge from the trap start, and the check for it is made only in the cycle after the (TRAP_LAT-1)-th later edge.

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
  parameter int W        = 4,
  parameter int NSLOT    = 6,
  parameter int NT       = 2,
  parameter int SEQW     = 16,
  parameter int PCW      = 32,
  parameter int HITW     = 16,
  parameter int TRAP_LAT = 3,
  parameter int unsigned RESET_PC = 0,
  localparam int TIDW    = (NT > 1) ? $clog2(NT) : 1,
  localparam int CNTW    = $clog2(W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT-1:0]      slot_grant,
  input  logic [NSLOT*TIDW-1:0] slot_tid,
  input  logic [NSLOT-1:0]      slot_ready,
  input  logic [NSLOT-1:0]      slot_squashed,
  input  logic [NSLOT-1:0]      slot_executed,
  input  logic [NSLOT-1:0]      slot_nonspec,
  input  logic [NSLOT-1:0]      slot_load,
  input  logic [NSLOT-1:0]      slot_fault,
  input  logic [NSLOT-1:0]      slot_nocount,
  input  logic [NSLOT*SEQW-1:0] slot_seq,
  input  logic [NSLOT*PCW-1:0]  slot_npc,
  input  logic                  stores_pending,
  output logic [NSLOT-1:0]      head_pop,
  output logic [CNTW-1:0]       retired_count,
  output logic [CNTW-1:0]       completed_count,
  output logic                  width_hit,
  output logic [HITW-1:0]       width_hit_cnt,
  output logic                  free_update,
  output logic                  done_valid,
  output logic [SEQW-1:0]       done_seq,
  output logic                  release_valid,
  output logic [TIDW-1:0]       release_tid,
  output logic [SEQW-1:0]       release_seq,
  output logic                  replay_req,
  output logic                  trap_start,
  output logic [TIDW-1:0]       trap_tid,
  output logic [NT-1:0]         trap_pending,
  output logic [NT-1:0]         trap_squash,
  output logic [NT*PCW-1:0]     arch_pc,
  output logic [NT*PCW-1:0]     arch_npc
);

  localparam int TMRW = (TRAP_LAT > 1) ? $clog2(TRAP_LAT) : 1;
  localparam logic [CNTW-1:0] WMAX = CNTW'(W);
  localparam logic [PCW-1:0]  ISZ  = PCW'(4);

  logic [NT-1:0]     upd;
  logic [NT*PCW-1:0] upd_npc;

  always_comb begin
    logic alive;
    logic [TIDW-1:0] t;
    head_pop        = '0;
    retired_count   = '0;
    completed_count = '0;
    done_valid      = 1'b0;
    done_seq        = '0;
    release_valid   = 1'b0;
    release_tid     = '0;
    release_seq     = '0;
    replay_req      = 1'b0;
    trap_start      = 1'b0;
    trap_tid        = '0;
    upd             = '0;
    upd_npc         = '0;
    alive           = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      t = slot_tid[i*TIDW +: TIDW];
      if (alive && retired_count < WMAX) begin
        if (!slot_grant[i] || trap_pending[t] || !slot_ready[i]) begin
          alive = 1'b0;
        end else if (slot_squashed[i]) begin
          head_pop[i] = 1'b1;
        end else if (!slot_executed[i]) begin
          alive = 1'b0;
          if (slot_load[i] && !slot_nonspec[i]) begin
            release_valid = 1'b1;
            replay_req    = 1'b1;
            release_tid   = t;
            release_seq   = slot_seq[i*SEQW +: SEQW];
          end else if (slot_nonspec[i] && retired_count == '0 && !stores_pending) begin
            release_valid = 1'b1;
            release_tid   = t;
            release_seq   = slot_seq[i*SEQW +: SEQW];
          end
        end else if (slot_fault[i]) begin
          alive = 1'b0;
          if (retired_count == '0 && !stores_pending) begin
            trap_start = 1'b1;
            trap_tid   = t;
          end
        end else begin
          head_pop[i]   = 1'b1;
          retired_count = retired_count + 1'b1;
          if (!slot_nocount[i]) completed_count = completed_count + 1'b1;
          done_valid = 1'b1;
          done_seq   = slot_seq[i*SEQW +: SEQW];
          upd[t]     = 1'b1;
          upd_npc[int'(t)*PCW +: PCW] = slot_npc[i*PCW +: PCW];
        end
      end
    end
  end

  assign width_hit   = (retired_count == WMAX);
  assign free_update = |head_pop;

  always_ff @(posedge clk) begin
    if (!rst_n)         width_hit_cnt <= '0;
    else if (width_hit) width_hit_cnt <= width_hit_cnt + 1'b1;
  end

  for (genvar g = 0; g < NT; g++) begin : g_thr
    logic [PCW-1:0]  pc_q, npc_q;
    logic [TMRW-1:0] tmr_q;
    logic            pend_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q  <= PCW'(RESET_PC);
        npc_q <= PCW'(RESET_PC) + ISZ;
      end else if (upd[g]) begin
        pc_q  <= upd_npc[g*PCW +: PCW];
        npc_q <= upd_npc[g*PCW +: PCW] + ISZ;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        tmr_q  <= '0;
      end else if (trap_start && trap_tid == TIDW'(g)) begin
        pend_q <= 1'b1;
        tmr_q  <= TMRW'(TRAP_LAT - 1);
      end else if (pend_q) begin
        if (tmr_q == '0) pend_q <= 1'b0;
        else             tmr_q  <= tmr_q - 1'b1;
      end
    end

    assign trap_pending[g]          = pend_q;
    assign trap_squash[g]           = pend_q && (tmr_q == '0);
    assign arch_pc[g*PCW +: PCW]    = pc_q;
    assign arch_npc[g*PCW +: PCW]   = npc_q;

    // R5
    trap_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_start && trap_tid == TIDW'(g)) |=> trap_pending[g]);

    // R6
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(upd[g]) |-> (arch_npc[g*PCW +: PCW] == arch_pc[g*PCW +: PCW] + ISZ));
  end

  // R4
  replay_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> release_valid);

  // R5
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_start |-> !release_valid && !done_valid);

  // R8
  hit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width_hit |=> width_hit_cnt == $past(width_hit_cnt) + 1'b1);

  // R9
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retired_count != '0) |-> free_update);

endmodule

// File: tb/retire_ctrl_bench.sv
`timescale 1ns/1ps
module retire_ctrl_bench;
  localparam int W = 4, NSLOT = 6, NT = 2, SEQW = 16, PCW = 32, HITW = 16, TRAP_LAT = 3;
  localparam int TIDW = 1, CNTW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSLOT-1:0] grant, tidv, ready, squashed, executed, nonspec, load, fault, nocount;
  logic [NSLOT*SEQW-1:0] seqv;
  logic [NSLOT*PCW-1:0]  npcv;
  logic stores;
  logic [NSLOT-1:0] head_pop;
  logic [CNTW-1:0] retired_count, completed_count;
  logic width_hit, free_update, done_valid, release_valid, replay_req, trap_start;
  logic [HITW-1:0] width_hit_cnt;
  logic [SEQW-1:0] done_seq, release_seq;
  logic [TIDW-1:0] release_tid, trap_tid;
  logic [NT-1:0] trap_pending, trap_squash;
  logic [NT*PCW-1:0] arch_pc, arch_npc;

  always #2.5 clk = ~clk;

  retire_ctrl #(.W(W), .NSLOT(NSLOT), .NT(NT), .SEQW(SEQW), .PCW(PCW), .HITW(HITW),
                .TRAP_LAT(TRAP_LAT), .RESET_PC(0)) u_retire_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_grant(grant), .slot_tid(tidv), .slot_ready(ready),
    .slot_squashed(squashed), .slot_executed(executed), .slot_nonspec(nonspec),
    .slot_load(load), .slot_fault(fault), .slot_nocount(nocount), .slot_seq(seqv),
    .slot_npc(npcv), .stores_pending(stores), .head_pop(head_pop),
    .retired_count(retired_count), .completed_count(completed_count),
    .width_hit(width_hit), .width_hit_cnt(width_hit_cnt), .free_update(free_update),
    .done_valid(done_valid), .done_seq(done_seq), .release_valid(release_valid),
    .release_tid(release_tid), .release_seq(release_seq), .replay_req(replay_req),
    .trap_start(trap_start), .trap_tid(trap_tid), .trap_pending(trap_pending),
    .trap_squash(trap_squash), .arch_pc(arch_pc), .arch_npc(arch_npc));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // codes: 0 none, 1 normal, 2 squashed, 3 not counted, 4 not ready,
  //        5 unexecuted non-speculative, 6 unexecuted load, 7 fault
  task automatic set_slot(input int i, input int code, input int tid, input int seq, input logic [31:0] npc);
    grant[i]    = (code != 0);
    ready[i]    = (code != 4);
    squashed[i] = (code == 2);
    executed[i] = !(code == 5 || code == 6);
    nonspec[i]  = (code == 5);
    load[i]     = (code == 6);
    fault[i]    = (code == 7);
    nocount[i]  = (code == 3);
    tidv[i]     = tid[0];
    seqv[i*SEQW +: SEQW] = seq[15:0];
    npcv[i*PCW +: PCW]   = npc;
  endtask

  task automatic clear_slots();
    for (int i = 0; i < NSLOT; i++) set_slot(i, 0, 0, 0, 32'h0);
    stores = 1'b0;
  endtask

  typedef struct packed {
    logic        st;
    logic [17:0] codes;
    logic [5:0]  pop;
    logic [2:0]  cnt;
    logic [2:0]  comp;
    logic        rel;
    logic        rep;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{1'b0, {3'd1,3'd1,3'd1,3'd1,3'd1,3'd1}, 6'h0F, 3'd4, 3'd4, 1'b0, 1'b0},
    '{1'b0, {3'd1,3'd1,3'd1,3'd1,3'd2,3'd2}, 6'h3F, 3'd4, 3'd4, 1'b0, 1'b0},
    '{1'b0, {3'd1,3'd1,3'd1,3'd1,3'd0,3'd1}, 6'h01, 3'd1, 3'd1, 1'b0, 1'b0},
    '{1'b0, {3'd1,3'd1,3'd1,3'd1,3'd4,3'd1}, 6'h01, 3'd1, 3'd1, 1'b0, 1'b0},
    '{1'b0, {3'd1,3'd1,3'd1,3'd1,3'd1,3'd5}, 6'h00, 3'd0, 3'd0, 1'b1, 1'b0},
    '{1'b1, {3'd1,3'd1,3'd1,3'd1,3'd1,3'd5}, 6'h00, 3'd0, 3'd0, 1'b0, 1'b0},
    '{1'b0, {3'd1,3'd1,3'd1,3'd1,3'd5,3'd1}, 6'h01, 3'd1, 3'd1, 1'b0, 1'b0},
    '{1'b1, {3'd1,3'd1,3'd1,3'd1,3'd6,3'd1}, 6'h01, 3'd1, 3'd1, 1'b1, 1'b1},
    '{1'b0, {3'd0,3'd0,3'd0,3'd3,3'd1,3'd3}, 6'h07, 3'd3, 3'd1, 1'b0, 1'b0},
    '{1'b1, {3'd0,3'd0,3'd0,3'd0,3'd7,3'd2}, 6'h01, 3'd0, 3'd0, 1'b0, 1'b0},
    '{1'b0, {3'd0,3'd0,3'd0,3'd0,3'd7,3'd1}, 6'h01, 3'd1, 3'd1, 1'b0, 1'b0},
    '{1'b0, {3'd1,3'd2,3'd2,3'd2,3'd2,3'd2}, 6'h3F, 3'd1, 3'd1, 1'b0, 1'b0},
    '{1'b0, {3'd3,3'd3,3'd3,3'd3,3'd3,3'd3}, 6'h0F, 3'd4, 3'd0, 1'b0, 1'b0}
  };

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_pc;
    int hits;
    clear_slots();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pc0", arch_pc[31:0], 0);
    chk("R11 npc0", arch_npc[31:0], 4);
    chk("R11 pc1", arch_pc[63:32], 0);
    chk("R11 hitcnt", width_hit_cnt, 0);
    chk("R11 pending", trap_pending, 0);
    chk("R1 idle count", retired_count, 0);
    exp_pc = 0;
    hits = 0;

    for (int v = 0; v < 13; v++) begin
      int last, npop;
      @(negedge clk);
      stores = TBL[v].st;
      for (int i = 0; i < NSLOT; i++)
        set_slot(i, int'(TBL[v].codes[3*i +: 3]), 0, v*16 + i, 32'h1000 + v*64 + i*4 + 4);
      #1;
      chk($sformatf("R1/R2 pop v%0d", v), head_pop, TBL[v].pop);
      chk($sformatf("R8 count v%0d", v), retired_count, TBL[v].cnt);
      chk($sformatf("R7 completed v%0d", v), completed_count, TBL[v].comp);
      chk($sformatf("R3 release v%0d", v), release_valid, TBL[v].rel);
      chk($sformatf("R4 replay v%0d", v), replay_req, TBL[v].rep);
      chk($sformatf("R9 free v%0d", v), free_update, TBL[v].pop != 0);
      chk($sformatf("R5 no trap v%0d", v), trap_start, 0);
      chk($sformatf("R8 hit v%0d", v), width_hit, TBL[v].cnt == 3'd4);
      if (TBL[v].cnt == 3'd4) hits++;
      npop = $countones(TBL[v].pop);
      if (TBL[v].rel) chk($sformatf("R3 release seq v%0d", v), release_seq, v*16 + npop);
      last = -1;
      for (int i = 0; i < NSLOT; i++)
        if (TBL[v].pop[i] && (TBL[v].codes[3*i +: 3] == 3'd1 || TBL[v].codes[3*i +: 3] == 3'd3)) last = i;
      if (last >= 0) begin
        chk($sformatf("R6 done seq v%0d", v), done_seq, v*16 + last);
        exp_pc = 32'h1000 + v*64 + last*4 + 4;
      end
      @(posedge clk);
      #1;
      chk($sformatf("R6/R2 pc v%0d", v), arch_pc[31:0], exp_pc);
      chk($sformatf("R6 npc v%0d", v), arch_npc[31:0], exp_pc + 4);
    end
    chk("R8 hit counter", width_hit_cnt, hits);

    // R5 trap start on thread 1, then R10 blocking
    @(negedge clk);
    clear_slots();
    set_slot(0, 7, 1, 16'h0500, 32'h2004);
    #1;
    chk("R5 trap start", trap_start, 1);
    chk("R5 trap tid", trap_tid, 1);
    chk("R5 no pop", head_pop, 0);
    @(posedge clk);
    @(negedge clk);
    clear_slots();
    chk("R5 pending set", trap_pending[1], 1);
    chk("R5 squash low e0", trap_squash[1], 0);
    set_slot(0, 1, 1, 16'h0501, 32'h3004);
    set_slot(1, 1, 0, 16'h0502, 32'h4004);
    #1;
    chk("R10 blocked thread stops walk", retired_count, 0);
    @(posedge clk);
    @(negedge clk);
    clear_slots();
    chk("R5 squash low e1", trap_squash[1], 0);
    chk("R10 pc1 unchanged", arch_pc[63:32], 0);
    set_slot(0, 1, 0, 16'h0503, 32'h5004);
    #1;
    chk("R10 other thread retires", retired_count, 1);
    @(posedge clk);
    @(negedge clk);
    clear_slots();
    chk("R5 squash pulse", trap_squash[1], 1);
    chk("R5 still pending", trap_pending[1], 1);
    chk("R6 pc0 other thread", arch_pc[31:0], 32'h5004);
    @(posedge clk);
    @(negedge clk);
    chk("R5 pending cleared", trap_pending[1], 0);
    chk("R5 squash gone", trap_squash[1], 0);
    set_slot(0, 1, 1, 16'h0504, 32'h6004);
    #1;
    chk("R10 thread unblocked", retired_count, 1);
    @(posedge clk);
    #1;
    chk("R6 pc1", arch_pc[63:32], 32'h6004);
    chk("R6 npc1", arch_npc[63:32], 32'h6008);

    // R5 fault with stores pending waits
    @(negedge clk);
    clear_slots();
    stores = 1'b1;
    set_slot(0, 7, 0, 16'h0600, 32'h7004);
    #1;
    chk("R5 fault waits on stores", trap_start, 0);
    @(negedge clk);
    clear_slots();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule